// File: doc/BRIEF.md
# Burst SRAM Address Control Unit

This block is the address and cycle-control front end of a synchronous burst SRAM. On every rising clock edge it looks at two address strobes, an advance input, three chip enables and the external address. From these it keeps an internal word address and a burst counter on the low address bits, and it tells the array stage three things:
- whether a cycle is in progress,
- whether the device is deselected,
- whether the current cycle may carry a write.

Each strobe interrupts any burst in progress and loads a new address. The processor-side strobe has priority over the controller-side strobe, always starts a read, and is ignored while the primary enable is inactive. The controller-side strobe starts a cycle that may be either a read or a write. The chip enables matter only on a cycle that loads an address. Between loads, the advance input either steps the burst counter or holds it, which gives a wait state. A static mode pin picks linear or interleaved burst order. A snooze input freezes all state and masks the cycle-valid output.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While rst_ni is low, the outputs are desel_o=1, valid_o=0, wr_ok_o=0 and addr_o=0.
- R2: A controller load is a clock edge with ctl_strb_ni=0, no accepted processor strobe, and all enables active (ce_ni=0, ce2_i=1, ce3_ni=0). After a controller load, addr_o equals the sampled addr_i, desel_o=0, valid_o=1 and wr_ok_o=1.
- R3: An edge with ctl_strb_ni=0 and ce_ni=1 deselects the device: desel_o=1 and valid_o=0. This holds whatever proc_strb_ni is.
- R4: A processor load is an edge with proc_strb_ni=0 and all enables active. It loads addr_i with desel_o=0, valid_o=1 and wr_ok_o=0 (read only), whatever ctl_strb_ni is.
- R5: While ce_ni=1, proc_strb_ni has no effect on any output.
- R6: An accepted strobe with ce_ni=0 but ce2_i=0 or ce3_ni=1 deselects the device.
- R7: On edges with no accepted strobe, ce_ni, ce2_i and ce3_ni have no effect.
- R8: With no accepted strobe, the device selected and adv_ni=0, the burst count steps by one modulo 4 and wr_ok_o=1. Address bits above bit 1 do not change.
- R9: With no accepted strobe, the device selected and adv_ni=1, addr_o holds, valid_o stays 1 and wr_ok_o=1. This wait state lets a write follow a processor load at the loaded address.
- R10: With mode_i=0 (linear), addr_o[1:0] = (start[1:0] + count) mod 4. With mode_i=1 (interleaved), addr_o[1:0] = start[1:0] XOR count. Here count is the number of steps since the last load.
- R11: While zz_i=1, every other input is ignored, the address and burst state are kept, and valid_o=0. When zz_i returns to 0, operation resumes from the kept state.
- R12: While deselected, adv_ni has no effect: desel_o stays 1 until a strobe loads with all enables active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_strb_ni | input | 1 | Controller-side address strobe, active low |
| proc_strb_ni | input | 1 | Processor-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_ni | input | 1 | Third chip enable, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| zz_i | input | 1 | Snooze, active high |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Internal word address for the array |
| valid_o | output | 1 | A cycle is in progress |
| desel_o | output | 1 | Deselected / power-down |
| wr_ok_o | output | 1 | The current cycle may be a write |

## Verification
The hardest situations to reach are those where the strobe rules overlap. Examples are both strobes low with one secondary enable inactive, a processor strobe arriving while the primary enable is high, and a snooze that starts in the middle of a wrapping burst. Directed sequences build each of these on top of a burst already in flight, so the wrap, the held state and the priority decision are all visible at addr_o. A long pseudo-random phase then keeps the strobes rare and the enables mostly active, so that bursts run long enough to wrap between loads. Both burst orders are used, with the mode changed only while the device is deselected.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    EV_IDLE,
    EV_SNOOZE,
    EV_LOAD_RD,
    EV_LOAD_RW,
    EV_DESEL,
    EV_ADV,
    EV_WAIT
  } bac_event_e;
endpackage

// File: rtl/bac_strobe_dec.sv
module bac_strobe_dec
  import bac_pkg::*;
(
  input  logic       proc_strb_ni,
  input  logic       ctl_strb_ni,
  input  logic       adv_ni,
  input  logic       ce_ni,
  input  logic       ce2_i,
  input  logic       ce3_ni,
  input  logic       zz_i,
  input  logic       sel_i,
  output bac_event_e ev_o
);
  logic proc_acc, ctl_acc, en_ok;

  assign proc_acc = !proc_strb_ni && !ce_ni;  // proc strobe needs primary enable
  assign ctl_acc  = !ctl_strb_ni;
  assign en_ok    = !ce_ni && ce2_i && !ce3_ni;

  always_comb begin
    if (zz_i)          ev_o = EV_SNOOZE;
    else if (proc_acc) ev_o = en_ok ? EV_LOAD_RD : EV_DESEL;
    else if (ctl_acc)  ev_o = en_ok ? EV_LOAD_RW : EV_DESEL;
    else if (!sel_i)   ev_o = EV_IDLE;
    else if (!adv_ni)  ev_o = EV_ADV;
    else               ev_o = EV_WAIT;
  end
endmodule

// File: rtl/bac_burst_cnt.sv
module bac_burst_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;  // wraps modulo 2**CNT_W
  end

  assign cnt_o = cnt_q;

  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/bac_order.sv
module bac_order #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             mode_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] lin, ilv;

  assign lin = start_i + cnt_i;
  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ cnt_i[b];
  end
  assign low_o = mode_i ? ilv : lin;
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import bac_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_strb_ni,
  input  logic              proc_strb_ni,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              mode_i,
  input  logic              zz_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              desel_o,
  output logic              wr_ok_o
);
  localparam int unsigned UP_W = ADDR_W - CNT_W;

  bac_event_e        ev;
  logic              sel_q, wr_ok_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  low;
  logic              load, step;

  bac_strobe_dec i_dec (
    .proc_strb_ni (proc_strb_ni),
    .ctl_strb_ni  (ctl_strb_ni),
    .adv_ni       (adv_ni),
    .ce_ni        (ce_ni),
    .ce2_i        (ce2_i),
    .ce3_ni       (ce3_ni),
    .zz_i         (zz_i),
    .sel_i        (sel_q),
    .ev_o         (ev)
  );

  assign load = (ev == EV_LOAD_RD) || (ev == EV_LOAD_RW);
  assign step = (ev == EV_ADV);

  bac_burst_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      wr_ok_q <= 1'b0;
      base_q  <= '0;
    end else begin
      unique case (ev)
        EV_LOAD_RD: begin sel_q <= 1'b1; wr_ok_q <= 1'b0; base_q <= addr_i; end
        EV_LOAD_RW: begin sel_q <= 1'b1; wr_ok_q <= 1'b1; base_q <= addr_i; end
        EV_DESEL:   begin sel_q <= 1'b0; wr_ok_q <= 1'b0; end
        EV_ADV, EV_WAIT: wr_ok_q <= 1'b1;
        default: ;
      endcase
    end
  end

  bac_order #(.CNT_W(CNT_W)) i_order (
    .mode_i  (mode_i),
    .start_i (base_q[CNT_W-1:0]),
    .cnt_i   (cnt),
    .low_o   (low)
  );

  assign addr_o  = {base_q[ADDR_W-1 -: UP_W], low};
  assign valid_o = sel_q && !zz_i;
  assign desel_o = !sel_q;
  assign wr_ok_o = wr_ok_q;

  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !ctl_strb_ni && proc_strb_ni && !ce_ni && ce2_i && !ce3_ni)
    |=> (!desel_o && wr_ok_o && base_q == $past(addr_i))); // R2
  AST_CE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !ctl_strb_ni && ce_ni) |=> desel_o); // R3
  AST_PROC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !proc_strb_ni && !ce_ni && ce2_i && !ce3_ni)
    |=> (!desel_o && !wr_ok_o && base_q == $past(addr_i))); // R4
  AST_SUB_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !ce_ni && (!proc_strb_ni || !ctl_strb_ni) && (!ce2_i || ce3_ni))
    |=> desel_o); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && proc_strb_ni && ctl_strb_ni && adv_ni)
    |=> ($stable(cnt) && $stable(base_q))); // R9
  AST_SNOOZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |=> ($stable(cnt) && $stable(base_q) && $stable(sel_q))); // R11
  AST_DESEL_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desel_o && ctl_strb_ni && (proc_strb_ni || ce_ni)) |=> desel_o); // R12
endmodule

// File: tb/test_burst_addr_ctrl.sv
module test_burst_addr_ctrl;
  localparam int AW = 20;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ctl_n = 1'b1, proc_n = 1'b1, adv_n = 1'b1;
  logic ce_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0, mode = 1'b0, zz = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_o;
  logic valid_o, desel_o, wr_ok_o;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_sel = 0, m_wr = 0, m_base = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_ctrl #(.ADDR_W(AW)) i_burst_addr_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_strb_ni(ctl_n), .proc_strb_ni(proc_n),
    .adv_ni(adv_n), .ce_ni(ce_n), .ce2_i(ce2), .ce3_ni(ce3_n), .mode_i(mode),
    .zz_i(zz), .addr_i(addr), .addr_o(addr_o), .valid_o(valid_o),
    .desel_o(desel_o), .wr_ok_o(wr_ok_o)
  );

  function automatic int exp_addr();
    int lo;
    lo = mode ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4);
    return (m_base & ~3) | lo;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    chk(req, "addr_o", int'(addr_o), exp_addr());
    chk(req, "valid_o", int'(valid_o), (m_sel != 0 && !zz) ? 1 : 0);
    chk(req, "desel_o", int'(desel_o), m_sel ? 0 : 1);
    chk(req, "wr_ok_o", int'(wr_ok_o), m_wr);
  endtask

  // behavioural reference, evaluated with the inputs present at the edge
  task automatic model_edge();
    bit en_ok;
    en_ok = !ce_n && ce2 && !ce3_n;
    if (zz) return;
    if (!proc_n && !ce_n) begin
      if (en_ok) begin m_sel = 1; m_wr = 0; m_base = int'(addr); m_cnt = 0; end
      else begin m_sel = 0; m_wr = 0; end
    end else if (!ctl_n) begin
      if (en_ok) begin m_sel = 1; m_wr = 1; m_base = int'(addr); m_cnt = 0; end
      else begin m_sel = 0; m_wr = 0; end
    end else if (m_sel != 0) begin
      m_wr = 1;
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
    end
  endtask

  task automatic tick(string req);
    @(posedge clk_i);
    model_edge();
    #1;
    compare(req);
  endtask

  task automatic idle();
    ctl_n = 1; proc_n = 1; adv_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    compare("R1");  // reset state
    #20;
    rst_ni = 1'b1;
    tick("R1");
    tick("R12");

    // R2 controller load, R8/R10 linear burst with wrap
    addr = 20'h12345; ctl_n = 0; tick("R2");
    idle(); adv_n = 0;
    for (int i = 0; i < 5; i++) tick("R8");
    adv_n = 1; tick("R9");
    // R7 enables toggled mid-burst have no effect
    ce_n = 1; ce2 = 0; ce3_n = 1; adv_n = 0; tick("R7");
    adv_n = 1; tick("R7");
    ce_n = 0; ce2 = 1; ce3_n = 0;

    // R4 processor load beats controller strobe, read only; then wait state
    addr = 20'hABCD2; proc_n = 0; ctl_n = 0; tick("R4");
    idle(); tick("R9");
    adv_n = 0; tick("R10"); tick("R10");

    // R5 proc strobe ignored while primary enable high
    idle(); ce_n = 1; proc_n = 0; adv_n = 0; addr = 20'h00007; tick("R5");
    adv_n = 1; tick("R5");
    // R3 controller strobe with primary enable high deselects
    ctl_n = 0; tick("R3");
    idle(); ce_n = 0;
    // R12 adv while deselected
    adv_n = 0; tick("R12"); tick("R12");

    // R6 secondary enables inactive
    idle(); addr = 20'h55551; ctl_n = 0; tick("R2");
    idle(); proc_n = 0; ce2 = 0; tick("R6");
    idle(); ce2 = 1; ctl_n = 0; tick("R2");
    idle(); ce3_n = 1; ctl_n = 0; tick("R6");
    idle(); ce3_n = 0;

    // R10 interleaved order, mode changed only while deselected
    mode = 1; tick("R10");
    addr = 20'hF00F1; ctl_n = 0; tick("R10");
    idle(); adv_n = 0;
    for (int i = 0; i < 5; i++) tick("R10");

    // R11 snooze mid-burst ignores strobes and advance
    zz = 1; adv_n = 0; tick("R11");
    ctl_n = 0; proc_n = 0; addr = 20'h11111; tick("R11");
    ce_n = 1; tick("R11");
    ce_n = 0; idle(); adv_n = 0; zz = 0; tick("R11"); tick("R11");
    idle(); ctl_n = 0; ce_n = 1; tick("R3");
    idle(); ce_n = 0;

    // pseudo-random phase, linear mode then interleaved
    for (int ph = 0; ph < 2; ph++) begin
      idle(); tick("R12");
      mode = ph[0];
      for (int i = 0; i < 1500; i++) begin
        ctl_n  = ($urandom % 8) != 0;
        proc_n = ($urandom % 10) != 0;
        adv_n  = $urandom % 2;
        ce_n   = ($urandom % 5) == 0;
        ce2    = ($urandom % 6) != 0;
        ce3_n  = ($urandom % 6) == 0;
        zz     = ($urandom % 25) == 0;
        addr   = AW'($urandom);
        tick("R8");
      end
      zz = 0; ctl_n = 0; ce_n = 1; tick("R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule